// File: doc/BRIEF.md
# Video Clock Divider and Routing Tree

This block produces the per-consumer pixel-rate clock enables of a display pipeline. All clocks are modelled as single-cycle enable pulses in one fast clock domain. Each source is one bit of `src_tick` that pulses at that source's rate.

Two divider chains are built from the same chain module, a main chain and an auxiliary chain. Each chain selects one source and divides it by a programmable integer N. It then derives five fixed taps from the divided pulse, at /1, /2, /4, /6 and /12, and each tap has its own gate. Four consumers each pick a tap through their own 4-bit selector and have their own gate: an interlaced encoder, a progressive encoder, a video DAC and a serial display transmitter. The auxiliary chain's /1 tap can be selected by any consumer.

Configuration uses a plain write port with a 3-bit word address and 32-bit data. Each write replaces the whole word. At reset every field is zero, so nothing pulses until software configures the block. There is no data stream in this block, so every pin is a plain control or status signal and none has back-pressure.

Top module: `vclk_tree`

## Requirements
- R1: After reset all four consumer outputs stay low until the block is configured.
- R2: Address 0 (main) and address 2 (auxiliary) hold the divide field in bits 7:0, written as N-1. The chain then emits one divided pulse every N selected source pulses, so the value 54 divides by 55.
- R3: A chain divides only while its enable (bit 16 of its divide word) is 1 and its reset (bit 17) is 0. With the enable at 0, or the reset at 1, no consumer fed by that chain pulses.
- R4: Bits 18:16 of the control word (address 1 main, address 3 auxiliary) select source `src_tick[code]`. Codes equal to or above NUM_SRC (5) select no source and produce no pulses.
- R5: Control-word bits 0..4 gate the /1, /2, /4, /6 and /12 taps. A consumer that selects a tap whose gate is 0 gets no pulses, while other taps keep running.
- R6: Bit 19 of the control word is the chain's master enable. While it is 0, none of that chain's taps pulse.
- R7: Consumer select codes 0, 1, 2, 3 and 4 pick the main /1, /2, /4, /6 and /12 taps. A consumer's pulse period is then P·N·ratio, where P is the source period. The selectors are: interlaced encoder at bits 31:28 of address 0, progressive encoder at bits 27:24 of address 0, DAC at bits 31:28 of address 2, and transmitter at bits 19:16 of address 5.
- R8: Select code 8 picks the auxiliary chain's /1 tap. Codes 5, 6, 7 and 9 to 15 give no pulses.
- R9: Address 4 holds the consumer gates: interlaced encoder at bit 0, progressive encoder at bit 2, DAC at bit 4 and transmitter at bit 5. A consumer whose gate is 0 gets no pulses.
- R10: Control-word bit 15 is the soft reset of the tap counters. While it is 1, no taps pulse. After it is cleared, all tap counters restart together. As a result, the first /6 pulse follows the first /4 pulse by exactly 2·N·P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One enable pulse per source clock edge, one bit per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| enc_i_tick | output | 1 | Interlaced-encoder clock enable |
| enc_p_tick | output | 1 | Progressive-encoder clock enable |
| dac_tick | output | 1 | Video DAC clock enable |
| tx_tick | output | 1 | Serial transmitter clock enable |

## Verification
Phase alignment of the taps is the hardest behaviour to observe from the ports. Before a soft reset, the tap counters hold arbitrary counts, and each consumer output only shows its own period. To expose alignment, the bench holds the soft reset, routes the interlaced encoder to /4 and the progressive encoder to /6, and then releases the reset. It timestamps the first pulse on each output and compares their distance with 2·N·P. A sweep over sources, divide values and all five taps on all four consumers covers the period arithmetic.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  localparam int DIV_W    = 8;
  localparam int SRC_W    = 3;
  localparam int SEL_W    = 4;
  localparam int NTAP     = 5;
  localparam int NCONS    = 4;
  localparam int NCHAIN   = 2;
  localparam int TAP_CW   = 4;
  localparam int AUX_CODE = 8;

  // divide word fields
  localparam int B_DIV_EN   = 16;
  localparam int B_DIV_RST  = 17;
  localparam int F_SEL_HI   = 28;
  localparam int F_SEL_LO   = 24;
  // control word fields
  localparam int F_SRC      = 16;
  localparam int B_MASTER   = 19;
  localparam int B_SOFT_RST = 15;
  // transmitter selector word
  localparam int F_TX_SEL   = 16;

  // consumer index order
  localparam int C_ENC_I = 0;
  localparam int C_ENC_P = 1;
  localparam int C_DAC   = 2;
  localparam int C_TX    = 3;

  typedef struct packed {
    logic [DIV_W-1:0] div_m1;
    logic             div_en;
    logic             div_rst;
    logic [SRC_W-1:0] src;
    logic             master;
    logic             soft_rst;
    logic [NTAP-1:0]  tap_gate;
  } chain_cfg_t;

  function automatic int tap_ratio(input int k);
    case (k)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 6;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/vclk_chain.sv
module vclk_chain
  import vclk_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  chain_cfg_t         cfg,
  output logic [NTAP-1:0]    tap_tick
);
  localparam int SRC_SPAN = 1 << SRC_W;

  logic [SRC_SPAN-1:0] src_pad;
  logic                sel_tick;
  logic [DIV_W-1:0]    div_cnt;
  logic                div_pulse;

  assign src_pad  = SRC_SPAN'(src_tick);
  assign sel_tick = src_pad[cfg.src];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= 1'b0;
      if (cfg.div_rst) begin
        div_cnt <= '0;
      end else if (cfg.div_en && sel_tick) begin
        if (div_cnt >= cfg.div_m1) begin
          div_cnt   <= '0;
          div_pulse <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  a_r3_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.div_rst || !cfg.div_en) |=> !div_pulse);

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam int RATIO = tap_ratio(k);
    logic [TAP_CW-1:0] tcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tcnt        <= '0;
        tap_tick[k] <= 1'b0;
      end else begin
        tap_tick[k] <= 1'b0;
        if (cfg.soft_rst) begin
          tcnt <= '0;
        end else if (div_pulse) begin
          if (tcnt == TAP_CW'(RATIO - 1)) begin
            tcnt        <= '0;
            tap_tick[k] <= cfg.master && cfg.tap_gate[k];
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end
    end

    a_r5_tap_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.tap_gate[k] |=> !tap_tick[k]);
  end

  a_r6_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.master |=> (tap_tick == '0));
  a_r10_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.soft_rst |=> (tap_tick == '0));
endmodule

// File: rtl/vclk_route.sv
module vclk_route
  import vclk_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NTAP-1:0]             main_tap,
  input  logic                        aux_tap,
  input  logic [NCONS-1:0][SEL_W-1:0] sel,
  input  logic [NCONS-1:0]            gate,
  output logic [NCONS-1:0]            cons_tick
);
  localparam int CODES = 1 << SEL_W;

  logic [CODES-1:0] tap_pad;

  always_comb begin
    tap_pad               = '0;
    tap_pad[NTAP-1:0]     = main_tap;
    tap_pad[AUX_CODE]     = aux_tap;
  end

  for (genvar i = 0; i < NCONS; i++) begin : g_cons
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cons_tick[i] <= 1'b0;
      else        cons_tick[i] <= gate[i] && tap_pad[sel[i]];
    end

    a_r9_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !gate[i] |=> !cons_tick[i]);
    a_r8_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[i] >= SEL_W'(NTAP) && sel[i] != SEL_W'(AUX_CODE)) |=> !cons_tick[i]);
  end
endmodule

// File: rtl/vclk_tree.sv
module vclk_tree
  import vclk_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               enc_i_tick,
  output logic               enc_p_tick,
  output logic               dac_tick,
  output logic               tx_tick
);
  localparam logic [ADDR_W-1:0] A_GATE   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TX_SEL = ADDR_W'(5);

  chain_cfg_t                  cfg_q [NCHAIN];
  logic [NCONS-1:0][SEL_W-1:0] sel_q;
  logic [NCONS-1:0]            gate_q;
  logic [NTAP-1:0]             tap_w [NCHAIN];
  logic [NCONS-1:0]            cons_w;

  // addresses 0..3: bit 1 picks the chain, bit 0 picks divide or control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHAIN; c++) cfg_q[c] <= '0;
      sel_q  <= '0;
      gate_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < ADDR_W'(4)) begin
        if (!cfg_addr[0]) begin
          cfg_q[cfg_addr[1]].div_m1  <= cfg_wdata[DIV_W-1:0];
          cfg_q[cfg_addr[1]].div_en  <= cfg_wdata[B_DIV_EN];
          cfg_q[cfg_addr[1]].div_rst <= cfg_wdata[B_DIV_RST];
          if (cfg_addr[1]) begin
            sel_q[C_DAC]   <= cfg_wdata[F_SEL_HI +: SEL_W];
          end else begin
            sel_q[C_ENC_I] <= cfg_wdata[F_SEL_HI +: SEL_W];
            sel_q[C_ENC_P] <= cfg_wdata[F_SEL_LO +: SEL_W];
          end
        end else begin
          cfg_q[cfg_addr[1]].src      <= cfg_wdata[F_SRC +: SRC_W];
          cfg_q[cfg_addr[1]].master   <= cfg_wdata[B_MASTER];
          cfg_q[cfg_addr[1]].soft_rst <= cfg_wdata[B_SOFT_RST];
          cfg_q[cfg_addr[1]].tap_gate <= cfg_wdata[NTAP-1:0];
        end
      end else if (cfg_addr == A_GATE) begin
        gate_q <= {cfg_wdata[5], cfg_wdata[4], cfg_wdata[2], cfg_wdata[0]};
      end else if (cfg_addr == A_TX_SEL) begin
        sel_q[C_TX] <= cfg_wdata[F_TX_SEL +: SEL_W];
      end
    end
  end

  for (genvar g = 0; g < NCHAIN; g++) begin : g_chain
    vclk_chain #(.NUM_SRC(NUM_SRC)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .cfg      (cfg_q[g]),
      .tap_tick (tap_w[g])
    );
  end

  vclk_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_tap  (tap_w[0]),
    .aux_tap   (tap_w[1][0]),
    .sel       (sel_q),
    .gate      (gate_q),
    .cons_tick (cons_w)
  );

  assign enc_i_tick = cons_w[C_ENC_I];
  assign enc_p_tick = cons_w[C_ENC_P];
  assign dac_tick   = cons_w[C_DAC];
  assign tx_tick    = cons_w[C_TX];

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q == '0) |=> (cons_w == '0));
endmodule

// File: tb/sim_vclk_tree.sv
module sim_vclk_tree;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_tick = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        enc_i_tick, enc_p_tick, dac_tick, tx_tick;
  logic [3:0]  cons;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int src_ph [5];
  int aux_div_word = 0;

  vclk_tree u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .enc_i_tick(enc_i_tick),
    .enc_p_tick(enc_p_tick), .dac_tick(dac_tick), .tx_tick(tx_tick)
  );

  assign cons = {tx_tick, dac_tick, enc_p_tick, enc_i_tick};

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // source k pulses once every k+2 cycles
  initial begin
    for (int k = 0; k < 5; k++) src_ph[k] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 5; k++) begin
        src_ph[k] = (src_ph[k] == k + 1) ? 0 : src_ph[k] + 1;
        src_tick[k] = (src_ph[k] == 0);
      end
    end
  end

  function automatic int ratio(input int k);
    case (k)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 12;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_pulse(input int c, input int lim, output int t);
    t = -1;
    for (int i = 0; i < lim && t < 0; i++) begin
      @(negedge clk);
      if (cons[c]) t = cyc;
    end
  endtask

  task automatic measure(input int c, input int exp, input string req);
    int t0, t1, t2, act;
    wait_pulse(c, 4 * exp + 200, t0);
    wait_pulse(c, 2 * exp + 20, t1);
    wait_pulse(c, 2 * exp + 20, t2);
    act = (t0 < 0 || t1 < 0 || t2 < 0) ? -1 : t2 - t1;
    check(act == exp, req, $sformatf("period on consumer %0d", c), act, exp);
  endtask

  task automatic silent(input int c, input int n, input string req);
    int hits = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cons[c]) hits++;
    end
    check(hits == 0, req, $sformatf("pulses on consumer %0d", c), hits, 0);
  endtask

  // main chain: one selector code for all consumers, soft reset pulse last
  task automatic setup(input int src, input int n, input int code,
                       input int tgates, input int master, input int cgates);
    wr(0, (code << 28) | (code << 24) | (1 << 16) | (n - 1));
    wr(2, (code << 28) | aux_div_word);
    wr(5, code << 16);
    wr(4, cgates);
    wr(1, (master << 19) | (src << 16) | (1 << 15) | tgates);
    wr(1, (master << 19) | (src << 16) | tgates);
  endtask

  initial begin
    int t4, t6;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet after reset
    for (int c = 0; c < 4; c++) silent(c, 100, "R1");

    // R7 sweep: sources, divide values, every tap on every consumer
    for (int s = 0; s < 3; s++)
      for (int ni = 0; ni < 2; ni++)
        for (int tp = 0; tp < 5; tp++) begin
          int n = (ni == 0) ? 1 : 3;
          setup(s, n, tp, 5'h1F, 1, 6'h35);
          for (int c = 0; c < 4; c++) measure(c, (s + 2) * n * ratio(tp), "R7");
        end

    // R7: independent selectors on two consumers
    setup(0, 2, 0, 5'h1F, 1, 6'h35);
    wr(0, (4 << 28) | (0 << 24) | (1 << 16) | 1);
    measure(0, 2 * 2 * 12, "R7");
    measure(1, 2 * 2, "R7");

    // R2: value 54 divides by 55
    setup(0, 55, 0, 5'h1F, 1, 6'h35);
    measure(0, 2 * 55, "R2");
    setup(0, 55, 1, 5'h1F, 1, 6'h35);
    measure(0, 2 * 55 * 2, "R2");

    // R3: divider enable low, then reset high
    setup(0, 2, 0, 5'h1F, 1, 6'h35);
    wr(0, 1);
    silent(0, 100, "R3");
    wr(0, (1 << 17) | (1 << 16) | 1);
    silent(0, 100, "R3");
    wr(0, (1 << 16) | 1);
    measure(0, 4, "R3");

    // R4: source codes above the last source
    wr(1, (1 << 19) | (6 << 16) | 5'h1F);
    silent(0, 100, "R4");
    wr(1, (1 << 19) | (7 << 16) | 5'h1F);
    silent(0, 100, "R4");
    wr(1, (1 << 19) | (4 << 16) | 5'h1F);
    measure(0, 6 * 2, "R4");

    // R5: tap gate for /2 off; /4 on another consumer keeps running
    setup(1, 2, 1, 5'h1D, 1, 6'h35);
    wr(0, (1 << 28) | (2 << 24) | (1 << 16) | 1);
    silent(0, 100, "R5");
    measure(1, 3 * 2 * 4, "R5");

    // R6: master enable off
    setup(1, 2, 0, 5'h1F, 0, 6'h35);
    silent(0, 100, "R6");
    silent(3, 50, "R6");

    // R8: auxiliary /1 tap through code 8, unused codes
    setup(0, 2, 0, 5'h1F, 1, 6'h35);
    aux_div_word = (1 << 16) | 1;
    wr(3, (1 << 19) | (1 << 16) | 1);
    wr(2, (8 << 28) | aux_div_word);
    wr(5, 8 << 16);
    measure(2, 3 * 2, "R8");
    measure(3, 3 * 2, "R8");
    wr(0, (5 << 28) | (9 << 24) | (1 << 16) | 1);
    silent(0, 100, "R8");
    silent(1, 50, "R8");
    wr(5, 15 << 16);
    silent(3, 50, "R8");

    // R9: interlaced-encoder gate off, progressive stays on
    setup(0, 2, 0, 5'h1F, 1, 6'h34);
    silent(0, 100, "R9");
    measure(1, 4, "R9");
    wr(4, 6'h15);
    silent(3, 50, "R9");

    // R10: held soft reset is quiet; release aligns /4 and /6
    setup(1, 2, 0, 5'h1F, 1, 6'h35);
    wr(0, (2 << 28) | (3 << 24) | (1 << 16) | 1);
    wr(1, (1 << 19) | (1 << 16) | (1 << 15) | 5'h1F);
    silent(0, 100, "R10");
    wr(1, (1 << 19) | (1 << 16) | 5'h1F);
    t4 = -1; t6 = -1;
    for (int i = 0; i < 500 && (t4 < 0 || t6 < 0); i++) begin
      @(negedge clk);
      if (enc_i_tick && t4 < 0) t4 = cyc;
      if (enc_p_tick && t6 < 0) t6 = cyc;
    end
    check(t4 >= 0 && t6 >= 0 && (t6 - t4) == 2 * 2 * 3, "R10",
          "first /6 minus first /4", t6 - t4, 12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule